// File: doc/BRIEF.md
# Serial EPROM Boot Loader

This block fetches a chip's start-up instruction stream from an external serial EPROM. It starts by itself when reset is released, and it starts again from the very beginning whenever a one-cycle reboot request is applied. Every load first sends three addressing bytes to the EPROM. It then shifts in seven-byte instruction records until it meets an opcode byte that marks the end of the list.

Each byte on the serial line takes nine serial clocks: eight data bits, most significant first, and then an acknowledge slot. The serial clock is a plain output produced from the system clock. Its period is one of two parameterised values, chosen by a select input. The select input is captured when a load starts.

Each complete record goes to a downstream consumer over a valid/ready handshake. If the consumer has not taken the previous record, the serial clock pauses before the next record. With a consumer that is always ready, the load time is fixed by the record count and the chosen period. A missing acknowledge during the addressing bytes ends the load and raises an error flag.

Top module: `sprom_boot_seq`

## Requirements
- R1: A load begins when reset is released, and again in the cycle after `reboot_i` is sampled high, whatever state the block is in. A reboot restarts at the first addressing byte, clears `err_o`, withdraws any pending record, and holds `busy_o` high.
- R2: The three addressing bytes are sent in order with `sd_oe_o` high. The default values are 0xA0, 0x00 and 0xA1, and each byte is sent MSB first. In each ninth slot `sd_oe_o` is low so that the EPROM can answer.
- R3: Every byte occupies exactly nine `sck_o` pulses. One pulse lasts PER_FAST system cycles when `slow_sel_i` was 0 at load start, and PER_SLOW cycles when it was 1, with half of each pulse high. `sd_i` is sampled as `sck_o` rises, and `sck_o` only pulses while `busy_o` is high.
- R4: A record is seven bytes read MSB first with `sd_oe_o` low. In each record's ninth slot the block drives `sd_o` low with `sd_oe_o` high. The first byte read appears on `rec_data_o[55:48]` and the last on `rec_data_o[7:0]`.
- R5: `rec_valid_o` stays high and `rec_data_o` stays unchanged until `rec_ready_i` is seen high. No bit of the next record is clocked in before the current record is accepted.
- R6: A record whose first byte is 0xFF is the end marker. The load ends after that byte's ninth slot, and the marker is never delivered as a record.
- R7: With `rec_ready_i` held high, `busy_o` stays high for exactly (3 + 7·N + 1) · 9 · P system cycles after a reboot. N is the number of records and P is the selected pulse length.
- R8: If `sd_i` is high when the ninth slot of an addressing byte is sampled, the load ends in that cycle. `busy_o` falls, `err_o` rises, `sck_o` stays low, and no record is delivered.
- R9: When a reboot request and a missing acknowledge fall in the same cycle, the reboot wins. `err_o` stays low and a complete load follows.
- R10: While `busy_o` is low, `sck_o` and `sd_oe_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; release starts a load |
| reboot_i | input | 1 | One-cycle request to restart the load |
| slow_sel_i | input | 1 | Pulse length select, captured at load start: 0 PER_FAST, 1 PER_SLOW |
| sd_i | input | 1 | Serial data from the EPROM |
| sck_o | output | 1 | Serial clock to the EPROM |
| sd_o | output | 1 | Serial data to the EPROM |
| sd_oe_o | output | 1 | Output enable for `sd_o` |
| busy_o | output | 1 | High while a load is in progress |
| err_o | output | 1 | Set when an addressing byte is not acknowledged |
| rec_valid_o | output | 1 | A record is waiting on `rec_data_o` |
| rec_ready_i | input | 1 | Consumer accepts the record |
| rec_data_o | output | 56 | Seven record bytes, first byte in the top bits |

## Verification
A reboot request and the acknowledge check of an addressing byte can land on the same clock edge. In that case the restart must win over the abort. The bench makes the EPROM model withhold the acknowledge of the third addressing byte. It then counts system cycles from a previous reboot so that a second reboot is sampled on exactly the edge where that ninth slot is sampled. The result is judged on the next cycle, where `err_o` must be low and `busy_o` high, and then by a full, error-free load with every record correct.

// File: rtl/sprom_boot_pkg.sv
// Package: sprom_boot_pkg
// Shared state and segment types plus the fixed serial framing constants
// used by the serial EPROM boot loader. Assumes byte-wide EPROM data.
package sprom_boot_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } boot_st_e;

    typedef enum logic {
        SEG_ADDR = 1'b0,
        SEG_REC  = 1'b1
    } seg_e;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ACK_SLOT = 8;   // ninth slot of a byte, counted from 0

endpackage

// File: rtl/sprom_sck_timer.sv
// Module: sprom_sck_timer
// Produces the slow serial clock from the system clock as a registered
// output, plus two strobes: the sample point (the rising edge of sck) and
// the end of the pulse. Assumes even period values of at least 2 and
// PER_SLOW >= PER_FAST. While run is low, the phase and sck hold.
module sprom_sck_timer #(
    parameter int unsigned PER_FAST = 330,
    parameter int unsigned PER_SLOW = 660
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic stop,
    input  logic run,
    input  logic slow,
    output logic sck_o,
    output logic smp_o,
    output logic bend_o
);

    localparam int unsigned PW = $clog2(PER_SLOW + 1);

    logic [PW-1:0] ph_q;
    logic [PW-1:0] per_last;
    logic [PW-1:0] half_last;

    // Purpose: choose the last phase count of a pulse and of its low half.
    always_comb begin
        per_last  = slow ? PW'(PER_SLOW - 1)     : PW'(PER_FAST - 1);
        half_last = slow ? PW'(PER_SLOW / 2 - 1) : PW'(PER_FAST / 2 - 1);
    end

    assign smp_o  = run && (ph_q == half_last);
    assign bend_o = run && (ph_q == per_last);

    // Purpose: advance the phase counter and shape the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= '0;
            sck_o <= 1'b0;
        end else if (restart || stop) begin
            ph_q  <= '0;
            sck_o <= 1'b0;
        end else if (run) begin
            ph_q <= bend_o ? '0 : ph_q + 1'b1;
            if (smp_o) begin
                sck_o <= 1'b1;
            end else if (bend_o) begin
                sck_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sprom_rec_assembler.sv
// Module: sprom_rec_assembler
// Collects received bytes into a record and offers each full record on a
// valid/ready pair. Assumes REC_N >= 2 and that the caller never pushes the
// last byte of a record while a record is still pending.
module sprom_rec_assembler #(
    parameter int unsigned REC_N = 7,
    parameter int unsigned BW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                push,
    input  logic                last_i,
    input  logic [BW-1:0]       byte_i,
    input  logic                ready_i,
    output logic                valid_o,
    output logic [REC_N*BW-1:0] data_o
);

    localparam int unsigned RW = REC_N * BW;

    logic [RW-1:0] acc_q;

    // Purpose: shift each incoming byte into the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (push) begin
            acc_q <= {acc_q[RW-BW-1:0], byte_i};
        end
    end

    // Purpose: publish a full record and retire it once it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else if (clr) begin
            valid_o <= 1'b0;
        end else begin
            if (valid_o && ready_i) begin
                valid_o <= 1'b0;
            end
            if (push && last_i) begin
                valid_o <= 1'b1;
                data_o  <= {acc_q[RW-BW-1:0], byte_i};
            end
        end
    end

endmodule

// File: rtl/sprom_boot_seq.sv
// Module: sprom_boot_seq
// Loads instruction records from a serial EPROM. It sends ADDR_N addressing
// bytes, then reads REC_N-byte records until a record opens with TERM_OP.
// Each byte takes nine serial clocks, and the ninth slot is an acknowledge.
// Assumes the EPROM changes sd_i while sck is low and that the external
// line is pulled high when nobody drives it.
module sprom_boot_seq #(
    parameter int unsigned             PER_FAST   = 330,
    parameter int unsigned             PER_SLOW   = 660,
    parameter int unsigned             ADDR_N     = 3,
    parameter int unsigned             REC_N      = 7,
    parameter logic [ADDR_N*8-1:0]     ADDR_BYTES = 24'hA0_00_A1,
    parameter logic [7:0]              TERM_OP    = 8'hFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reboot_i,
    input  logic                 slow_sel_i,
    input  logic                 sd_i,
    output logic                 sck_o,
    output logic                 sd_o,
    output logic                 sd_oe_o,
    output logic                 busy_o,
    output logic                 err_o,
    output logic                 rec_valid_o,
    input  logic                 rec_ready_i,
    output logic [REC_N*8-1:0]   rec_data_o
);

    import sprom_boot_pkg::*;

    localparam int unsigned MAXB = (ADDR_N > REC_N) ? ADDR_N : REC_N;
    localparam int unsigned CW   = (MAXB > 1) ? $clog2(MAXB) : 1;

    boot_st_e           st_q;
    seg_e               seg_q;
    logic [3:0]         bit_q;
    logic [CW-1:0]      byte_q;
    logic [BYTE_W-1:0]  sh_q;
    logic               slow_q;

    logic               smp, bend, stall, run;
    logic               in_addr, ack_slot, abort, byte_end, is_term;
    logic               push, last;
    logic [BYTE_W-1:0]  addr_byte;
    logic [2:0]         bsel;

    assign busy_o   = (st_q == ST_LOAD);
    assign in_addr  = (seg_q == SEG_ADDR);
    assign ack_slot = (bit_q == 4'(ACK_SLOT));
    assign stall    = busy_o && !in_addr && (byte_q == '0) && (bit_q == '0)
                      && rec_valid_o && !rec_ready_i;
    assign run      = busy_o && !stall;
    assign abort    = smp && in_addr && ack_slot && sd_i;
    assign byte_end = bend && ack_slot;
    assign is_term  = !in_addr && (byte_q == '0) && (sh_q == TERM_OP);
    assign push     = byte_end && !in_addr && !is_term;
    assign last     = (byte_q == CW'(REC_N - 1));
    assign bsel     = 3'(4'd7 - bit_q);

    // Purpose: pick the addressing byte that belongs to the current byte slot.
    always_comb begin
        addr_byte = '0;
        for (int k = 0; k < ADDR_N; k++) begin
            if (byte_q == CW'(k)) begin
                addr_byte = ADDR_BYTES[(ADDR_N-1-k)*8 +: 8];
            end
        end
    end

    // Purpose: drive the data line while sending addresses or acknowledging data.
    always_comb begin
        sd_oe_o = busy_o && (in_addr ? !ack_slot : ack_slot);
        sd_o    = busy_o && in_addr && !ack_slot && addr_byte[bsel];
    end

    sprom_sck_timer #(
        .PER_FAST (PER_FAST),
        .PER_SLOW (PER_SLOW)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (reboot_i),
        .stop    (abort),
        .run     (run),
        .slow    (slow_q),
        .sck_o   (sck_o),
        .smp_o   (smp),
        .bend_o  (bend)
    );

    sprom_rec_assembler #(
        .REC_N (REC_N),
        .BW    (BYTE_W)
    ) asm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (reboot_i),
        .push    (push),
        .last_i  (last),
        .byte_i  (sh_q),
        .ready_i (rec_ready_i),
        .valid_o (rec_valid_o),
        .data_o  (rec_data_o)
    );

    // Purpose: step through address bytes and records, bit by bit, until the end marker or an abort.
    always_ff @(posedge clk) begin
        if (!rst_n || reboot_i) begin
            st_q   <= ST_LOAD;
            seg_q  <= SEG_ADDR;
            bit_q  <= '0;
            byte_q <= '0;
            sh_q   <= '0;
            err_o  <= 1'b0;
            slow_q <= slow_sel_i;
        end else if (st_q == ST_LOAD) begin
            if (abort) begin
                st_q  <= ST_IDLE;
                err_o <= 1'b1;
            end else begin
                if (smp && !in_addr && !ack_slot) begin
                    sh_q <= {sh_q[BYTE_W-2:0], sd_i};
                end
                if (bend) begin
                    if (!ack_slot) begin
                        bit_q <= bit_q + 1'b1;
                    end else begin
                        bit_q <= '0;
                        if (in_addr) begin
                            if (byte_q == CW'(ADDR_N - 1)) begin
                                seg_q  <= SEG_REC;
                                byte_q <= '0;
                            end else begin
                                byte_q <= byte_q + 1'b1;
                            end
                        end else if (is_term) begin
                            st_q <= ST_IDLE;
                        end else begin
                            byte_q <= last ? '0 : byte_q + 1'b1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sprom_boot_seq_chk.sv
// Module: sprom_boot_seq_chk
// Checker holding the temporal properties of the boot loader, attached to
// every sprom_boot_seq instance by the bind statement below.
module sprom_boot_seq_chk #(
    parameter int unsigned DW = 56
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reboot_i,
    input logic          sck_o,
    input logic          sd_oe_o,
    input logic          busy_o,
    input logic          err_o,
    input logic          rec_valid_o,
    input logic          rec_ready_i,
    input logic [DW-1:0] rec_data_o
);

    // Restart after a reboot request.
    assert_reboot_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_i |=> busy_o && !err_o && !rec_valid_o);

    // Serial clock rises only inside a load.
    assert_sck_in_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> busy_o);

    // A record waits unchanged for the consumer.
    assert_record_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o && !rec_ready_i && !reboot_i |=> rec_valid_o && $stable(rec_data_o));

    // The error flag rises together with the end of the load.
    assert_abort_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !busy_o && !sck_o);

    // Quiet serial lines outside a load.
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sck_o && !sd_oe_o);

endmodule

bind sprom_boot_seq sprom_boot_seq_chk #(.DW(REC_N*8)) chk_i (.*);

// File: tb/sprom_boot_seq_tb_top.sv
module sprom_boot_seq_tb_top;

    localparam int PF = 4;
    localparam int PS = 8;
    localparam int AN = 3;
    localparam int RN = 7;
    localparam logic [23:0] AB = 24'hA0_00_A1;

    logic clk = 1'b0, rst_n = 1'b0, reboot = 1'b0, slow = 1'b0, rr = 1'b1;
    logic sd_i, sck, sd_o, sd_oe, busy, err, rv;
    logic [55:0] rd;

    always #5 clk = ~clk;

    sprom_boot_seq #(.PER_FAST(PF), .PER_SLOW(PS)) dut_i (
        .clk(clk), .rst_n(rst_n), .reboot_i(reboot), .slow_sel_i(slow),
        .sd_i(sd_i), .sck_o(sck), .sd_o(sd_o), .sd_oe_o(sd_oe),
        .busy_o(busy), .err_o(err), .rec_valid_o(rv), .rec_ready_i(rr),
        .rec_data_o(rd));

    int errors = 0, checks = 0;

    // EPROM model: slot counter advanced by sck rises
    logic [7:0] mem [0:127];
    int nack_byte = -1;
    int rc = 0;
    int line_bad = 0;
    logic mdl_clr = 1'b0;

    always @(posedge sck or posedge mdl_clr) begin
        if (mdl_clr) rc <= 0;
        else begin
            if (rc / 9 < AN) begin
                if (rc % 9 < 8) begin
                    if (!sd_oe || sd_o !== AB[(AN-1-rc/9)*8 + 7 - rc%9]) line_bad++;
                end else if (sd_oe) line_bad++;
            end else begin
                if (rc % 9 < 8) begin
                    if (sd_oe) line_bad++;
                end else if (!sd_oe || sd_o) line_bad++;
            end
            rc <= rc + 1;
        end
    end

    always_comb begin
        int b, t;
        b = rc / 9;
        t = rc % 9;
        if (b < AN) sd_i = (t == 8) ? (b == nack_byte) : 1'b1;
        else if (t < 8 && (b - AN) < 128) sd_i = mem[b-AN][7-t];
        else sd_i = 1'b1;
    end

    // consumer: ready pattern and record capture at the falling edge
    logic bp_mode = 1'b0;
    logic [7:0] lf = 8'h5A;
    logic [55:0] got [0:31];
    int nrec = 0;

    always @(negedge clk) begin
        if (bp_mode) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            rr = lf[0] & lf[1];
        end else rr = 1'b1;
        if (rv && rr) begin
            if (nrec < 32) got[nrec] = rd;
            nrec++;
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load_image(int n, int seed);
        for (int i = 0; i < 128; i++) mem[i] = 8'h00;
        for (int r = 0; r < n; r++)
            for (int b = 0; b < RN; b++)
                mem[r*RN+b] = (b == 0) ? 8'(r + 1) : 8'(seed + r*13 + b*29);
        mem[n*RN] = 8'hFF;
    endtask

    task automatic clear_model();
        mdl_clr = 1'b1;
        #1 mdl_clr = 1'b0;
    endtask

    // reboot pulse sampled by exactly one edge, then count busy cycles
    task automatic timed_load(output int cyc);
        @(negedge clk); #1;
        reboot = 1'b1; nrec = 0; line_bad = 0;
        clear_model();
        @(negedge clk); #1;
        reboot = 1'b0;
        cyc = 0;
        while (busy && cyc < 100000) begin
            cyc++;
            @(negedge clk); #1;
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 100000) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic check_records(int n, string req);
        chk(req, "record count", nrec, n);
        for (int r = 0; r < n && r < 32; r++) begin
            logic [55:0] e;
            for (int b = 0; b < RN; b++) e[(RN-1-b)*8 +: 8] = mem[r*RN+b];
            chk(req, $sformatf("record %0d", r), got[r], e);
        end
    endtask

    task automatic t_reset();
        load_image(2, 7);
        slow = 1'b0;
        clear_model();
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "busy in reset", busy, 1);
        chk("R10", "sck in reset", sck, 0);
        chk("R5", "valid in reset", rv, 0);
        chk("R8", "err in reset", err, 0);
        rst_n = 1'b1;
        wait_idle();
        check_records(2, "R1");
        chk("R2", "line errors", line_bad, 0);
        chk("R3", "sck pulses", rc, 18*9);
    endtask

    task automatic t_fast_timing();
        int cyc;
        load_image(2, 3);
        slow = 1'b0;
        timed_load(cyc);
        chk("R7", "busy cycles fast", cyc, 18*9*PF);
        chk("R3", "sck pulses fast", rc, 18*9);
        chk("R2", "line errors fast", line_bad, 0);
        check_records(2, "R4");
    endtask

    task automatic t_slow_timing();
        int cyc;
        load_image(13, 11);
        slow = 1'b1;
        timed_load(cyc);
        slow = 1'b0;
        chk("R7", "busy cycles slow", cyc, 95*9*PS);
        chk("R3", "sck pulses slow", rc, 95*9);
        check_records(13, "R4");
    endtask

    task automatic t_term_only();
        int cyc;
        load_image(0, 1);
        timed_load(cyc);
        chk("R6", "busy cycles marker only", cyc, 4*9*PF);
        chk("R6", "records after marker", nrec, 0);
        chk("R6", "err after marker", err, 0);
    endtask

    task automatic t_backpressure();
        int cyc;
        load_image(4, 21);
        bp_mode = 1'b1;
        timed_load(cyc);
        repeat (40) @(negedge clk);
        #1;
        bp_mode = 1'b0;
        chk("R5", "load not shorter than ideal", (cyc >= 32*9*PF), 1);
        check_records(4, "R5");
    endtask

    task automatic t_nack();
        int cyc;
        load_image(2, 5);
        nack_byte = 1;
        timed_load(cyc);
        chk("R8", "busy cycles until abort", cyc, 17*PF + PF/2);
        chk("R8", "err after abort", err, 1);
        chk("R8", "records after abort", nrec, 0);
        repeat (40) @(negedge clk);
        #1;
        chk("R10", "sck idle after abort", sck, 0);
        chk("R10", "oe idle after abort", sd_oe, 0);
        chk("R10", "no pulses after abort", rc, 17);
        nack_byte = -1;
    endtask

    task automatic t_reboot_mid();
        int cyc;
        load_image(3, 9);
        timed_load(cyc);
        @(negedge clk); #1;
        reboot = 1'b1; clear_model();
        @(negedge clk); #1;
        reboot = 1'b0;
        repeat (500) @(negedge clk);
        #1;
        chk("R1", "busy mid load", busy, 1);
        timed_load(cyc);
        chk("R1", "full time after mid reboot", cyc, 25*9*PF);
        chk("R1", "err after mid reboot", err, 0);
        check_records(3, "R1");
    endtask

    task automatic t_reboot_vs_nack();
        load_image(2, 17);
        nack_byte = 2;
        @(negedge clk); #1;
        reboot = 1'b1; nrec = 0;
        clear_model();
        @(negedge clk); #1;
        reboot = 1'b0;
        repeat (26*PF + PF/2 - 1) @(negedge clk);
        #1;
        reboot = 1'b1;
        @(negedge clk); #1;
        reboot = 1'b0;
        chk("R9", "err with coincident reboot", err, 0);
        chk("R9", "busy with coincident reboot", busy, 1);
        nack_byte = -1;
        nrec = 0; line_bad = 0;
        clear_model();
        wait_idle();
        chk("R9", "err after restarted load", err, 0);
        check_records(2, "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_fast_timing();
        t_slow_timing();
        t_term_only();
        t_backpressure();
        t_nack();
        t_reboot_mid();
        t_reboot_vs_nack();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule